// File: doc/BRIEF.md
# Single-Wire Bus Master Link Engine

This block is the master side of the link layer for an open-drain bus that carries data and timing on one line. A host hands it one command at a time over a valid/ready handshake. The command is a bus reset with a presence check, a byte write, a byte read or a single-bit read. The engine then times the bus waveform itself with cycle counters derived from the clock frequency. Its only drive onto the line is an active-low pull-down enable. It samples the line through a two-flop synchronizer.

Some slaves on such a bus draw their supply from the line. They need a hard pull-up while they convert or store data. If the host asks for it, and the byte just written is 44h (convert) or 48h (copy), the engine switches a strong pull-up on right after the last write slot. It keeps it on for a number of microseconds given with the command. During that time it starts no slot and no reset. Each command ends with a one-cycle result pulse that carries the read byte and the presence flag.

The controller has seven states:
- IDLE: waits for a command with ready high.
- PULSE_LOW: the reset pulse.
- LISTEN: released, with presence sampling.
- SLOT: one write or read slot.
- RECOVER: released gap between slots.
- BOOST: strong pull-up held.
- DONE: result pulse.

The transitions are:
- IDLE goes to PULSE_LOW on an accepted reset, or to SLOT on any other accepted command.
- PULSE_LOW goes to LISTEN when the low time expires.
- LISTEN goes to DONE at the end of the listen time.
- SLOT goes to RECOVER at slot end. After the final slot of a qualifying write it goes to BOOST instead.
- RECOVER goes back to SLOT while bits remain, or to DONE after the last one.
- BOOST goes to DONE when the hold count is reached.
- DONE returns to IDLE.

Top module: `sw_link_engine`

## Requirements
- R1: A reset command (op code 0) pulls the line low for 500 µs, then releases it for 500 µs, then ends. The line is never held low longer than the reset low time.
- R2: The reset result carries presence = 1 if, and only if, the synchronized line was seen low at some point from 10 µs up to (but not including) 300 µs after the release.
- R3: A write command (op code 1) sends its byte least significant bit first, as eight 70 µs slots, each followed by 5 µs released. A 1 bit pulls low for the first 6 µs of its slot. A 0 bit pulls low for the whole slot.
- R4: A read byte command (op code 2) runs eight slots. Each slot pulls low for 2 µs, is released for the rest of its 70 µs and is followed by 5 µs released. The line is sampled 12 µs into each slot. The first bit received is placed in bit 0 of the result byte.
- R5: A read bit command (op code 3) runs one such read slot. The sampled bit is returned in bit 0 of the result byte, with bits 7..1 zero.
- R6: A write of 44h or 48h with the boost request set raises the strong pull-up in the cycle right after the last slot ends, with no recovery gap. It holds the pull-up for (hold value × 1 µs + 1 cycle) and then ends the command.
- R7: A boost request is ignored for any other byte and for read commands. These commands then have exactly the waveform of the same command without the request.
- R8: The pull-down and the strong pull-up are never active together. While the pull-up is held, no command is accepted and no slot or reset begins.
- R9: Ready is high only when idle. A command offered while busy waits, stalled, and starts right after the current one ends. Each command produces exactly one one-cycle result pulse, in the cycle after its last phase. A write returns result byte 0.
- R10: After reset and between commands the line is released and the pull-up is off, for as long as the host stays silent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Engine accepts the command this cycle |
| cmd_op | input | 2 | 0 reset, 1 write byte, 2 read byte, 3 read bit |
| cmd_byte | input | 8 | Byte to write |
| cmd_boost | input | 1 | Request the strong pull-up after this write |
| cmd_boost_us | input | BOOST_W | Strong pull-up hold time in microseconds |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_byte | output | 8 | Read result (0 for writes) |
| rsp_present | output | 1 | Presence flag from the latest reset |
| line_in | input | 1 | Bus line level, asynchronous |
| line_pd_n | output | 1 | Pull-down enable, active low |
| boost_en | output | 1 | Strong pull-up enable |

## Verification
The assertions assume two things about the inputs. The host keeps a command's fields stable while it holds valid. The line can only be low when some agent pulls it, so a released line reads high after the synchronizer delay. The bench's slave model keeps to this. It drives the line as the AND of the engine's pull-down and its own pulls. It pulls only in answer to a falling edge (read bits) or a long reset (presence), and it releases well before the next slot begins. The host driver changes fields only between handshakes.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RDBIT = 2'd3
    } sw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE_LOW,
        ST_LISTEN,
        ST_SLOT,
        ST_RECOVER,
        ST_BOOST,
        ST_DONE
    } sw_state_e;

    localparam logic [7:0] BYTE_CONVERT = 8'h44;
    localparam logic [7:0] BYTE_STORE   = 8'h48;

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff <= {STAGES{RST_VAL}};
        end else begin
            ff <= {ff[STAGES-2:0], d};
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/sw_tick.sv
module sw_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/sw_link_engine.sv
module sw_link_engine
    import sw_pkg::*;
#(
    parameter int CLK_HZ       = 125_000_000,
    parameter int RST_LOW_US   = 500,
    parameter int LISTEN_US    = 500,
    parameter int PRES_FROM_US = 10,
    parameter int PRES_TO_US   = 300,
    parameter int SLOT_US      = 70,
    parameter int W1_LOW_US    = 6,
    parameter int RD_LOW_US    = 2,
    parameter int RD_SAMPLE_US = 12,
    parameter int RECOVER_US   = 5,
    parameter int BOOST_W      = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [7:0]         cmd_byte,
    input  logic               cmd_boost,
    input  logic [BOOST_W-1:0] cmd_boost_us,
    output logic               rsp_valid,
    output logic [7:0]         rsp_byte,
    output logic               rsp_present,
    input  logic               line_in,
    output logic               line_pd_n,
    output logic               boost_en
);
    localparam int US_CYC  = CLK_HZ / 1_000_000;
    localparam int LONG_US = (RST_LOW_US > LISTEN_US) ? RST_LOW_US : LISTEN_US;
    localparam int TW      = $clog2(LONG_US * US_CYC + 1);

    localparam logic [TW-1:0] C_RST_END  = TW'(RST_LOW_US * US_CYC - 1);
    localparam logic [TW-1:0] C_LIS_END  = TW'(LISTEN_US * US_CYC - 1);
    localparam logic [TW-1:0] C_PFROM    = TW'(PRES_FROM_US * US_CYC);
    localparam logic [TW-1:0] C_PTO      = TW'(PRES_TO_US * US_CYC);
    localparam logic [TW-1:0] C_SLOT     = TW'(SLOT_US * US_CYC);
    localparam logic [TW-1:0] C_SLOT_END = TW'(SLOT_US * US_CYC - 1);
    localparam logic [TW-1:0] C_W1       = TW'(W1_LOW_US * US_CYC);
    localparam logic [TW-1:0] C_RD       = TW'(RD_LOW_US * US_CYC);
    localparam logic [TW-1:0] C_RDS      = TW'(RD_SAMPLE_US * US_CYC);
    localparam logic [TW-1:0] C_REC_END  = TW'(RECOVER_US * US_CYC - 1);
    localparam logic [TW:0]   C_RST_W    = (TW + 1)'(RST_LOW_US * US_CYC);

    sw_state_e          state, state_d;
    logic [TW-1:0]      tcnt;
    logic [2:0]         bit_idx;
    sw_op_e             op_q;
    logic [7:0]         byte_q;
    logic [7:0]         wr_sh;
    logic [7:0]         rd_sh;
    logic               boost_q;
    logic [BOOST_W-1:0] hold_q;
    logic [BOOST_W-1:0] hold_cnt;
    logic               pres_q;
    logic               line_s;
    logic               us_tick;
    logic               last_bit;
    logic               boost_go;
    logic [TW-1:0]      low_len;
    logic               pull;

    sw_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    sw_tick #(.DIV(US_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_BOOST),
        .tick  (us_tick)
    );

    // Per-slot decode
    always_comb begin
        last_bit = (op_q == OP_RDBIT) || (bit_idx == 3'd7);
        boost_go = (op_q == OP_WRITE) && boost_q &&
                   ((byte_q == BYTE_CONVERT) || (byte_q == BYTE_STORE));
        if (op_q == OP_WRITE) begin
            low_len = wr_sh[0] ? C_W1 : C_SLOT;
        end else begin
            low_len = C_RD;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:      if (cmd_valid) state_d = (cmd_op == OP_RESET) ? ST_PULSE_LOW : ST_SLOT;
            ST_PULSE_LOW: if (tcnt == C_RST_END) state_d = ST_LISTEN;
            ST_LISTEN:    if (tcnt == C_LIS_END) state_d = ST_DONE;
            ST_SLOT:      if (tcnt == C_SLOT_END) state_d = (last_bit && boost_go) ? ST_BOOST : ST_RECOVER;
            ST_RECOVER:   if (tcnt == C_REC_END) state_d = last_bit ? ST_DONE : ST_SLOT;
            ST_BOOST:     if (hold_cnt == hold_q) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Timers and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            bit_idx  <= '0;
            op_q     <= OP_RESET;
            byte_q   <= '0;
            wr_sh    <= '0;
            rd_sh    <= '0;
            boost_q  <= 1'b0;
            hold_q   <= '0;
            hold_cnt <= '0;
            pres_q   <= 1'b0;
        end else begin
            tcnt <= (state_d != state) ? '0 : tcnt + TW'(1);
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= sw_op_e'(cmd_op);
                        byte_q  <= cmd_byte;
                        wr_sh   <= cmd_byte;
                        boost_q <= cmd_boost;
                        hold_q  <= cmd_boost_us;
                        rd_sh   <= '0;
                        bit_idx <= '0;
                        if (cmd_op == OP_RESET) pres_q <= 1'b0;
                    end
                end
                ST_LISTEN: begin
                    if (tcnt >= C_PFROM && tcnt < C_PTO && !line_s) pres_q <= 1'b1;
                end
                ST_SLOT: begin
                    hold_cnt <= '0;
                    if (op_q != OP_WRITE && tcnt == C_RDS) rd_sh <= {line_s, rd_sh[7:1]};
                    if (tcnt == C_SLOT_END) wr_sh <= {1'b0, wr_sh[7:1]};
                end
                ST_RECOVER: begin
                    if (state_d == ST_SLOT) bit_idx <= bit_idx + 3'd1;
                end
                ST_BOOST: begin
                    if (us_tick) hold_cnt <= hold_cnt + BOOST_W'(1);
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pull        = (state == ST_PULSE_LOW) || (state == ST_SLOT && tcnt < low_len);
        line_pd_n   = !pull;
        boost_en    = (state == ST_BOOST);
        cmd_ready   = (state == ST_IDLE);
        rsp_valid   = (state == ST_DONE);
        rsp_present = pres_q;
        unique case (op_q)
            OP_READ:  rsp_byte = rd_sh;
            OP_RDBIT: rsp_byte = {7'b0, rd_sh[7]};
            default:  rsp_byte = 8'h00;
        endcase
    end

    // Checker support: length of the current low run on the pull-down
    logic [TW:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!line_pd_n) begin
            low_run <= low_run + (TW + 1)'(1);
        end else begin
            low_run <= '0;
        end
    end

    AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !line_pd_n |-> (low_run < C_RST_W)) else $error("low run too long"); // R1
    AST_PRES_FROM_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_present) |-> $past(state) == ST_LISTEN) else $error("presence outside listen"); // R2
    AST_BOOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        boost_en |-> (hold_cnt <= hold_q)) else $error("boost overrun"); // R6
    AST_BOOST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost_en) |-> (op_q == OP_WRITE && boost_q &&
                             (byte_q == 8'h44 || byte_q == 8'h48))) else $error("boost not allowed"); // R7
    AST_NO_PULL_IN_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
        !(boost_en && !line_pd_n)) else $error("pull and boost together"); // R8
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("result pulse too long"); // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (line_pd_n && !boost_en)) else $error("idle not released"); // R10

endmodule

// File: tb/sim_sw_link_engine.sv
module sim_sw_link_engine;
    localparam int US     = 4;
    localparam int T_RST  = 500;
    localparam int T_LIS  = 500;
    localparam int T_PTO  = 300;
    localparam int T_SLOT = 70;
    localparam int T_W1   = 6;
    localparam int T_RD   = 2;
    localparam int T_REC  = 5;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        cmd_boost = 1'b0;
    logic [19:0] cmd_boost_us = 20'd0;
    logic        cmd_ready, rsp_valid, rsp_present, line_pd_n, boost_en;
    logic [7:0]  rsp_byte;
    logic        rd_low = 1'b0;
    logic        pr_low = 1'b0;
    logic        line_in;
    assign line_in = line_pd_n & ~rd_low & ~pr_low;

    sw_link_engine #(.CLK_HZ(4_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_boost(cmd_boost),
        .cmd_boost_us(cmd_boost_us), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .rsp_present(rsp_present), .line_in(line_in), .line_pd_n(line_pd_n),
        .boost_en(boost_en)
    );

    typedef struct {
        bit         pd_n;
        bit         bst;
        bit         rsp;
        bit         ck_d;
        logic [7:0] d;
        bit         ck_p;
        bit         p;
        string      tag;
    } exp_t;

    exp_t q[$];
    bit   slv_bits[$];
    bit   mdl_bits[$];
    bit   slv_present = 1'b1;
    int   pres_delay = 30;
    time  t_fall = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic void push(input int n, input bit pd_n, input bit bst, input string tag);
        for (int i = 0; i < n; i++) q.push_back('{pd_n, bst, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag});
    endfunction

    function automatic void push_done(input bit ck_d, input logic [7:0] d,
                                      input bit ck_p, input bit p, input string tag);
        q.push_back('{1'b1, 1'b0, 1'b1, ck_d, d, ck_p, p, tag});
    endfunction

    // Behavioural reference: the expected waveform of one accepted command
    function automatic void model_accept();
        case (cmd_op)
            2'd0: begin
                push(T_RST * US, 1'b0, 1'b0, "R1");
                push(T_LIS * US, 1'b1, 1'b0, "R1");
                push_done(1'b0, 8'h00, 1'b1, slv_present && (pres_delay < T_PTO), "R2");
            end
            2'd1: begin
                bit    go;
                string tg;
                go = cmd_boost && (cmd_byte == 8'h44 || cmd_byte == 8'h48);
                tg = (cmd_boost && !go) ? "R7" : "R3";
                for (int i = 0; i < 8; i++) begin
                    int lo;
                    lo = cmd_byte[i] ? T_W1 : T_SLOT;
                    push(lo * US, 1'b0, 1'b0, tg);
                    push((T_SLOT - lo) * US, 1'b1, 1'b0, tg);
                    if (i == 7 && go) push(int'(cmd_boost_us) * US + 1, 1'b1, 1'b1, "R6");
                    else push(T_REC * US, 1'b1, 1'b0, tg);
                end
                push_done(1'b1, 8'h00, 1'b0, 1'b0, "R9");
            end
            default: begin
                int         nb;
                logic [7:0] d;
                string      tg;
                nb = (cmd_op == 2'd2) ? 8 : 1;
                d  = 8'h00;
                tg = (nb == 8) ? (cmd_boost ? "R7" : "R4") : "R5";
                for (int i = 0; i < nb; i++) begin
                    bit b;
                    b = (mdl_bits.size() != 0) ? mdl_bits.pop_front() : 1'b1;
                    d[i] = b;
                    push(T_RD * US, 1'b0, 1'b0, tg);
                    push((T_SLOT - T_RD) * US, 1'b1, 1'b0, tg);
                    push(T_REC * US, 1'b1, 1'b0, tg);
                end
                push_done(1'b1, d, 1'b0, 1'b0, tg);
            end
        endcase
    endfunction

    // Cycle-by-cycle comparison
    exp_t e;
    bit   busy;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            busy = (q.size() != 0);
            if (busy) e = q[0];
            else e = '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R10"};
            check(line_pd_n == e.pd_n, e.tag, "pull_n", line_pd_n, e.pd_n);
            check(boost_en == e.bst, e.tag, "boost", boost_en, e.bst);
            check(cmd_ready == !busy, busy ? (e.bst ? "R8" : "R9") : "R10", "ready", cmd_ready, !busy);
            check(rsp_valid == e.rsp, "R9", "rsp_valid", rsp_valid, e.rsp);
            check(!(boost_en && !line_pd_n), "R8", "pull with boost", boost_en, 0);
            if (e.rsp && e.ck_d) check(rsp_byte == e.d, e.tag, "rsp_byte", rsp_byte, e.d);
            if (e.rsp && e.ck_p) check(rsp_present == e.p, e.tag, "presence", rsp_present, e.p);
            if (busy) void'(q.pop_front());
            else if (cmd_valid) model_accept();
        end
    end

    // Slave: read replies
    initial forever begin
        bit b;
        @(negedge line_pd_n);
        t_fall = $time;
        if (slv_bits.size() != 0) begin
            b = slv_bits.pop_front();
            if (!b) begin
                rd_low = 1'b1;
                repeat (30 * US) @(posedge clk);
                rd_low = 1'b0;
            end
        end
    end

    // Slave: presence after a long low
    initial forever begin
        @(posedge line_pd_n);
        if (($time - t_fall) > 400 * US * 8 && slv_present) begin
            repeat (pres_delay * US) @(posedge clk);
            pr_low = 1'b1;
            repeat (100 * US) @(posedge clk);
            pr_low = 1'b0;
        end
    end

    task automatic send(input logic [1:0] op, input logic [7:0] b, input bit bst, input int hold);
        @(posedge clk);
        #2;
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_byte     = b;
        cmd_boost    = bst;
        cmd_boost_us = 20'(hold);
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        @(posedge clk);
        #2;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0 || !cmd_ready);
    endtask

    task automatic load_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            slv_bits.push_back(v[i]);
            mdl_bits.push_back(v[i]);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R10", "ready after reset", cmd_ready, 1);
        check(line_pd_n == 1'b1, "R10", "line after reset", line_pd_n, 1);
        check(boost_en == 1'b0, "R10", "boost after reset", boost_en, 0);

        // R1 and R2: presence in window, late answer, no answer
        slv_present = 1'b1; pres_delay = 30;
        send(2'd0, 8'h00, 1'b0, 0); wait_idle();
        pres_delay = 350;
        send(2'd0, 8'h00, 1'b0, 0); wait_idle();
        slv_present = 1'b0;
        send(2'd0, 8'h00, 1'b0, 0); wait_idle();
        slv_present = 1'b1; pres_delay = 30;

        // R3 with back-to-back stalls (R9)
        send(2'd1, 8'hA5, 1'b0, 0);
        send(2'd1, 8'h00, 1'b0, 0);
        send(2'd1, 8'hFF, 1'b0, 0);
        wait_idle();

        // R6 and R8: boost after convert/store bytes, next command stalled
        send(2'd1, 8'h44, 1'b1, 40);
        send(2'd1, 8'h48, 1'b1, 3);
        send(2'd1, 8'h48, 1'b1, 0);
        send(2'd1, 8'h01, 1'b0, 0);
        wait_idle();

        // R7: request ignored
        send(2'd1, 8'h44, 1'b0, 40);
        send(2'd1, 8'h55, 1'b1, 40);
        wait_idle();

        // R4 and R5: reads
        load_bits(8'h3C, 8);
        send(2'd2, 8'h00, 1'b0, 0); wait_idle();
        load_bits(8'hC5, 8);
        send(2'd2, 8'h00, 1'b1, 40); wait_idle();
        load_bits(8'h00, 1);
        send(2'd3, 8'h00, 1'b0, 0); wait_idle();
        load_bits(8'h01, 1);
        send(2'd3, 8'h00, 1'b0, 0); wait_idle();

        // R10: long silence
        repeat (2000) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", q.size(), 0);
            summary();
            $finish;
        end
    end
endmodule